// File: doc/BRIEF.md
# Shared-Bus Driver Handover Controller

This block decides which of up to eight sources may drive one shared bus, and it makes sure that no two sources ever drive that bus in the same cycle. A select input names the wanted owner, and a global enable allows or forbids any driving at all. The block turns these into active-high, one-hot per-source enables. These are meant for the output-enable pins of the bus drivers.

Whenever the bus passes to a new owner, the block holds every enable low for a fixed number of clock cycles. This quiet gap covers worst-case turn-off and turn-on skew, so a slow driver that is letting go can never fight a fast driver that is taking over. The same gap applies when the bus is first driven after being off, even when the select has not changed. Releasing the bus needs no gap.

Next to the enables, the block gives a model of what the bus carries: the owner's data with a valid flag, or valid low when the bus floats. It also reports which source owns the bus and whether a gap is in progress.

Top module: `bus_handover_ctrl`

## Requirements
- R1: When a source is driving, exactly bit `own_idx` of `drv_en` is set, `own_idx` equals the select value that was granted, and `line_driven` is high.
- R2: `drv_en` is all-zero or one-hot in every cycle.
- R3: A low `go` sampled on a clock edge clears every enable on that same edge, with no gap. `line_driven` and `bus_valid` then read low.
- R4: When the sampled select differs from the current owner while `go` is high, the owner's enable drops on that edge. The next enable rises only after at least GAP_CYC cycles in which `drv_en` is all-zero.
- R5: When `go` is sampled high while nothing drives, a gap of GAP_CYC all-zero cycles comes before the grant. This holds even when the select equals the last owner. The grant falls on the (GAP_CYC+1)th edge that samples `go` high.
- R6: A select change during a gap neither restarts nor lengthens it. The grant goes to the select sampled on the edge that ends the gap.
- R7: `gap_busy` is high in exactly the cycles of a gap, and never while any enable is set. A low `go` during a gap ends the gap on that edge.
- R8: `bus_data` equals bits [8*i+7:8*i] of `src_data` for the driving source i, and `bus_valid` is high. When nothing drives, `bus_valid` is low and `bus_data` is zero.
- R9: A synchronous active-high reset clears all enables, `gap_busy` and `line_driven`. Leaving reset needs no gap wait.
- R10: While `go` stays high and the select keeps naming the current owner, the owner stays enabled with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Global permission to drive the bus |
| src_sel | input | 3 | Wanted owner index |
| src_data | input | 64 | Data of all sources, source i in bits [8i+7:8i] |
| drv_en | output | 8 | One-hot per-source enables |
| gap_busy | output | 1 | High during a dead-time gap |
| own_idx | output | 3 | Index of the driving source |
| line_driven | output | 1 | High when a source drives |
| bus_data | output | 8 | Modelled bus value |
| bus_valid | output | 1 | Low when the bus floats |

## Verification
Two things can fall on the same clock edge. A release of the bus through a low `go` can meet the end of a gap, and a select change can meet the final edge of a gap. The bench provokes both by moving `go` and `src_sel` on exactly those edges. It judges the result against a per-cycle model that tracks the remaining gap as an integer. A separate count of all-zero enable cycles before every rising enable checks that no handover ever got shorter.

// File: rtl/bus_handover_pkg.sv
package bus_handover_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GAP   = 2'd1,
    ST_DRIVE = 2'd2
  } hand_state_t;

  // Value loaded into the gap counter so that exactly gap_len
  // all-zero cycles are seen before the grant edge.
  function automatic int unsigned gap_reload(input int unsigned gap_len);
    return (gap_len > 0) ? gap_len - 1 : 0;
  endfunction

endpackage

// File: rtl/hand_gap_timer.sv
module hand_gap_timer #(
  parameter int unsigned GAP_CYC = 3,
  localparam int unsigned CNT_W  = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic clear,
  output logic running,
  output logic expired
);
  import bus_handover_pkg::*;

  localparam int unsigned RELOAD = gap_reload(GAP_CYC);
  localparam logic [CNT_W-1:0] RELOAD_V = CNT_W'(RELOAD);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= RELOAD_V;
      run_q <= 1'b1;
    end else if (run_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign running = run_q;
  assign expired = run_q && (cnt_q == '0);

endmodule

// File: rtl/hand_decoder.sv
module hand_decoder #(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC)
) (
  input  logic [SEL_W-1:0]   idx,
  input  logic               active,
  output logic [NUM_SRC-1:0] onehot
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_dec
    assign onehot[i] = active && (idx == SEL_W'(i));
  end
endmodule

// File: rtl/hand_resolver.sv
module hand_resolver #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DATA_W  = 8
) (
  input  logic [NUM_SRC*DATA_W-1:0] data_in,
  input  logic [NUM_SRC-1:0]        sel_oh,
  output logic [DATA_W-1:0]         data_out
);
  logic [DATA_W-1:0] masked [NUM_SRC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
    assign masked[i] = data_in[i*DATA_W +: DATA_W] & {DATA_W{sel_oh[i]}};
  end

  always_comb begin
    data_out = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      data_out = data_out | masked[i];
    end
  end
endmodule

// File: rtl/bus_handover_ctrl.sv
module bus_handover_ctrl #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned GAP_CYC = 3,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      go,
  input  logic [SEL_W-1:0]          src_sel,
  input  logic [NUM_SRC*DATA_W-1:0] src_data,
  output logic [NUM_SRC-1:0]        drv_en,
  output logic                      gap_busy,
  output logic [SEL_W-1:0]          own_idx,
  output logic                      line_driven,
  output logic [DATA_W-1:0]         bus_data,
  output logic                      bus_valid
);
  import bus_handover_pkg::*;

  hand_state_t      st_q, st_d;
  logic [SEL_W-1:0] idx_q, idx_d;
  logic             tmr_load, tmr_clear, tmr_run, tmr_done;

  // Named events, brought out for the checker
  logic ev_release;   // go fell while driving
  logic ev_switch;    // owner change requested while driving
  logic ev_start;     // gap begins from idle
  logic ev_grant;     // gap ends, new owner enabled
  logic ev_abort;     // go fell during a gap

  always_comb begin
    st_d       = st_q;
    idx_d      = idx_q;
    tmr_load   = 1'b0;
    tmr_clear  = 1'b0;
    ev_release = 1'b0;
    ev_switch  = 1'b0;
    ev_start   = 1'b0;
    ev_grant   = 1'b0;
    ev_abort   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (go) begin
          st_d     = ST_GAP;
          tmr_load = 1'b1;
          ev_start = 1'b1;
        end
      end
      ST_GAP: begin
        if (!go) begin
          st_d      = ST_IDLE;
          tmr_clear = 1'b1;
          ev_abort  = 1'b1;
        end else if (tmr_done) begin
          st_d      = ST_DRIVE;
          idx_d     = src_sel;
          tmr_clear = 1'b1;
          ev_grant  = 1'b1;
        end
      end
      ST_DRIVE: begin
        if (!go) begin
          st_d       = ST_IDLE;
          ev_release = 1'b1;
        end else if (src_sel != idx_q) begin
          st_d      = ST_GAP;
          tmr_load  = 1'b1;
          ev_switch = 1'b1;
        end
      end
      default: begin
        st_d      = ST_IDLE;
        tmr_clear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  hand_gap_timer #(.GAP_CYC(GAP_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .clear   (tmr_clear),
    .running (tmr_run),
    .expired (tmr_done)
  );

  hand_decoder #(.NUM_SRC(NUM_SRC)) u_dec (
    .idx    (idx_q),
    .active (st_q == ST_DRIVE),
    .onehot (drv_en)
  );

  hand_resolver #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_res (
    .data_in  (src_data),
    .sel_oh   (drv_en),
    .data_out (bus_data)
  );

  assign gap_busy    = tmr_run;
  assign own_idx     = idx_q;
  assign line_driven = (st_q == ST_DRIVE);
  assign bus_valid   = |drv_en;

endmodule

// File: rtl/bus_handover_chk.sv
module bus_handover_chk #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned GAP_CYC = 3,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst,
  input logic               go,
  input logic [NUM_SRC-1:0] drv_en,
  input logic               gap_busy,
  input logic [SEL_W-1:0]   own_idx,
  input logic               line_driven,
  input logic               bus_valid,
  input logic               ev_grant,
  input logic               ev_switch
);
  logic [15:0] zero_run;

  always_ff @(posedge clk) begin
    if (rst) zero_run <= '0;
    else if (drv_en != '0) zero_run <= '0;
    else if (zero_run != 16'hFFFF) zero_run <= zero_run + 1'b1;
  end

  a_r2_onehot0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drv_en));

  a_r1_index_match: assert property (@(posedge clk) disable iff (rst)
    line_driven |-> (drv_en[own_idx] && $countones(drv_en) == 1));

  a_r3_release_now: assert property (@(posedge clk) disable iff (rst)
    !go |=> (drv_en == '0 && !bus_valid));

  a_r4_no_direct_swap: assert property (@(posedge clk) disable iff (rst)
    (drv_en != '0) |=> (drv_en == '0 || drv_en == $past(drv_en)));

  a_r4_gap_length: assert property (@(posedge clk) disable iff (rst)
    (drv_en != '0 && $past(drv_en) == '0) |-> (zero_run >= 16'(GAP_CYC)));

  a_r4_switch_drops: assert property (@(posedge clk) disable iff (rst)
    ev_switch |=> (drv_en == '0 && gap_busy));

  a_r7_busy_quiet: assert property (@(posedge clk) disable iff (rst)
    gap_busy |-> (drv_en == '0));

  a_r7_grant_ends_gap: assert property (@(posedge clk) disable iff (rst)
    ev_grant |=> (!gap_busy && line_driven));

  a_r9_reset_clean: assert property (@(posedge clk)
    rst |=> (drv_en == '0 && !gap_busy && !line_driven));

endmodule

bind bus_handover_ctrl bus_handover_chk #(
  .NUM_SRC(NUM_SRC),
  .GAP_CYC(GAP_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .go         (go),
  .drv_en     (drv_en),
  .gap_busy   (gap_busy),
  .own_idx    (own_idx),
  .line_driven(line_driven),
  .bus_valid  (bus_valid),
  .ev_grant   (ev_grant),
  .ev_switch  (ev_switch)
);

// File: tb/tb_bus_handover_ctrl.sv
`timescale 1ns/1ps
module tb_bus_handover_ctrl;
  localparam int N   = 8;
  localparam int DW  = 8;
  localparam int GAP = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          go  = 1'b0;
  logic [2:0]    src_sel = '0;
  logic [N*DW-1:0] src_data;
  logic [N-1:0]  drv_en;
  logic          gap_busy, line_driven, bus_valid;
  logic [2:0]    own_idx;
  logic [DW-1:0] bus_data;

  logic [DW-1:0] slot [N];
  always_comb for (int i = 0; i < N; i++) src_data[i*DW +: DW] = slot[i];

  bus_handover_ctrl #(.NUM_SRC(N), .DATA_W(DW), .GAP_CYC(GAP)) dut (
    .clk(clk), .rst(rst), .go(go), .src_sel(src_sel), .src_data(src_data),
    .drv_en(drv_en), .gap_busy(gap_busy), .own_idx(own_idx),
    .line_driven(line_driven), .bus_data(bus_data), .bus_valid(bus_valid));

  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: owner flag, owner index, remaining quiet cycles
  bit m_on = 0, m_wait = 0;
  int m_idx = 0, m_left = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_on = 0; m_wait = 0; m_left = 0; m_idx = 0;
    end else if (!go) begin
      m_on = 0; m_wait = 0; m_left = 0;
    end else if (m_on) begin
      if (int'(src_sel) != m_idx) begin
        m_on = 0; m_wait = 1; m_left = GAP - 1;
      end
    end else if (!m_wait) begin
      m_wait = 1; m_left = GAP - 1;
    end else if (m_left > 0) begin
      m_left--;
    end else begin
      m_wait = 0; m_on = 1; m_idx = int'(src_sel);
    end
  end

  // Per-cycle comparison away from the active edge
  int zrun = 0;
  logic [N-1:0] prev_en = '0;
  always @(negedge clk) begin
    logic [N-1:0] e_en;
    logic [DW-1:0] e_dat;
    if (!rst && !finished) begin
      e_en  = m_on ? N'(1) << m_idx : '0;
      e_dat = m_on ? slot[m_idx] : '0;
      check(drv_en === e_en, "R1/R2 drv_en", drv_en, e_en);
      check(gap_busy === m_wait, "R7 gap_busy", gap_busy, m_wait);
      check(line_driven === m_on, "R1 line_driven", line_driven, m_on);
      check(bus_valid === m_on, "R8 bus_valid", bus_valid, m_on);
      check(bus_data === e_dat, "R8 bus_data", bus_data, e_dat);
      if (m_on) check(own_idx === 3'(m_idx), "R1 own_idx", own_idx, m_idx);
      if (drv_en != '0 && prev_en == '0)
        check(zrun >= GAP, "R4 quiet cycles before grant", zrun, GAP);
      if (drv_en != '0 && prev_en != '0 && drv_en != prev_en)
        check(0, "R4 direct swap", drv_en, prev_en);
    end
    zrun    = (rst || drv_en != '0) ? 0 : zrun + 1;
    prev_en = drv_en;
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic fill(input logic [3:0] seed);
    for (int i = 0; i < N; i++) slot[i] = {seed, 4'(i)};
  endtask

  initial begin
    fill(4'hA);
    step(3);
    rst = 0;
    step(1);
    check(drv_en == '0 && !gap_busy && !line_driven, "R9 reset state", drv_en, 0);

    // R5: start from idle, grant after GAP quiet cycles
    go = 1; src_sel = 3'd2;
    step(GAP);
    check(drv_en == '0, "R5 still quiet", drv_en, 0);
    step(1);
    check(drv_en == 8'h04, "R5 granted src 2", drv_en, 8'h04);

    // R10: hold owner, data follows
    step(4);
    fill(4'h3);
    #1 check(bus_data == 8'h32 && drv_en == 8'h04, "R10/R8 steady owner", bus_data, 8'h32);

    // R4 + R6: change owner, then change select inside the gap
    src_sel = 3'd5; step(1);
    check(drv_en == '0 && gap_busy, "R4 owner dropped first", drv_en, 0);
    src_sel = 3'd6; step(1);
    src_sel = 3'd1; step(GAP - 1);
    check(drv_en == 8'h02 && own_idx == 3'd1, "R6 newest select granted", drv_en, 8'h02);

    // R3: release needs no gap
    go = 0; step(1);
    check(drv_en == '0 && !bus_valid && bus_data == '0, "R3 immediate release", drv_en, 0);

    // R5: same select after off still waits
    go = 1; step(1);
    check(drv_en == '0 && gap_busy, "R5 gap on re-enable", drv_en, 0);
    step(GAP);
    check(drv_en == 8'h02, "R5 same owner back", drv_en, 8'h02);

    // R7: go drops exactly on the gap-ending edge
    src_sel = 3'd7; step(GAP);
    go = 0; step(1);
    check(drv_en == '0 && !gap_busy, "R7 abort at gap end", drv_en, 0);

    // Walk all sources
    go = 1;
    for (int s = 0; s < N; s++) begin
      src_sel = 3'(s); fill(4'(s + 5));
      step(GAP + 2);
      check(drv_en == (N'(1) << s), "R1 walk grant", drv_en, N'(1) << s);
    end

    // Toggle go quickly
    for (int k = 0; k < 6; k++) begin
      go = k[0]; src_sel = 3'(k * 3); step(1 + k % 3);
    end
    go = 1; step(GAP + 3);

    // R9: reset while driving
    rst = 1; step(1);
    check(drv_en == '0 && !line_driven, "R9 reset mid-drive", drv_en, 0);
    rst = 0; go = 0; step(2);
    check(drv_en == '0 && !gap_busy, "R9 idle after reset", drv_en, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule